// File: doc/BRIEF.md
# TDM Group Power-Down Bypass Path

This block carries the PCM samples of a 32-slot TDM frame in two directions, receive (`rin` to `rout`) and send (`sin` to `sout`). Each input beat carries one 8-bit sample per direction. The samples for one timeslot move together as a single beat. Slots are paired into 16 groups, and group g owns slots 2g and 2g+1. Each group has a power bit.

A group whose power bit is low is bypassed. Its samples come back unchanged on the matching outputs in the same slot two frames later. A group whose power bit is high sends its samples through a placeholder processing stage that has the same two-frame latency. The output timing therefore does not depend on the power state. A single-channel setting marks the odd slot of every powered group as don't-care. The block then drives a fixed idle code in that slot.

Both the input and the output are valid/ready streams. A beat transfers on a cycle where valid and ready are both high. The output stage holds one beat, and the input is stalled only while that beat is waiting on a low `out_ready`. `in_sof` marks slot 0, and every frame must begin with a beat that has `in_sof` set. The power bits and the single-channel setting are sampled on that beat and hold for the whole frame.

Top module: `tdm_group_bypass`

## Requirements
- R1: `in_ready` is high whenever the output register is empty or `out_ready` is high. An input beat is accepted when `in_valid` and `in_ready` are both high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sof`, `rout` and `sout` hold their values.
- R3: Each accepted input beat produces exactly one output beat, which is valid in the cycle after acceptance.
- R4: A beat with `in_sof` set is slot 0, and each later beat of the frame takes the next slot number. `out_sof` is high exactly on output beats for slot 0.
- R5: The output beat for slot s of frame n carries, in each direction, a value derived from the input of slot s in frame n-2.
- R6: In a group whose power bit is 0, both of its slots return the input of frame n-2 unchanged on `rout` and `sout`, whatever the single-channel setting.
- R7: In a powered group with `single_ch` = 0, both slots return the input of frame n-2 unchanged through the processing stage.
- R8: In a powered group with `single_ch` = 1, the even slot 2g is delayed as in R7, and the odd slot 2g+1 outputs the idle code 0xD5 on both `rout` and `sout`.
- R9: `pwr_up` and `single_ch` are sampled only on the accepted beat that has `in_sof` set. A change in the middle of a frame has no effect until the next frame starts.
- R10: While `rst_n` is low, `out_valid`, `rout` and `sout` are 0. After reset the delay store is cleared, so the first two frames output 0x00 in every slot that is not idle-coded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up | input | 16 | Power bit per group; bit g controls slots 2g and 2g+1 |
| single_ch | input | 1 | Single-channel setting: odd slot of each powered group is don't-care |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_sof | input | 1 | Input beat is slot 0 |
| rin | input | 8 | Receive-direction input sample |
| sin | input | 8 | Send-direction input sample |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sof | output | 1 | Output beat is slot 0 |
| rout | output | 8 | Receive-direction output sample |
| sout | output | 8 | Send-direction output sample |

## Verification
The stimulus runs several kinds of frame. Frames with every group powered down separate the bypass from any other path. Frames with every group powered up and `single_ch` low expose the processing stage alone. Mixed power masks with `single_ch` high show whether the odd-slot idle code is tied to the right group bit. A frame whose configuration changes at slot 10 shows whether the settings are sampled at the frame boundary or while the frame is running. A second reset in the middle of the run, followed by fresh frames, shows that the store is cleared. Random input bubbles and random output stalls run throughout, so the slot count and the two-frame alignment are checked under back-pressure and not only on an unbroken stream.

// File: rtl/tdm_bypass_pkg.sv
package tdm_bypass_pkg;

  typedef enum logic [1:0] {
    PATH_BYPASS = 2'd0,
    PATH_PROC   = 2'd1,
    PATH_IDLE   = 2'd2
  } path_e;

  // Route choice for one slot: an unpowered group is always bypassed;
  // in a powered group the odd slot is idle-coded in single-channel setting.
  function automatic path_e pick_path(input logic grp_on, input logic single,
                                      input logic odd);
    if (!grp_on)         return PATH_BYPASS;
    if (single && odd)   return PATH_IDLE;
    return PATH_PROC;
  endfunction

endpackage

// File: rtl/tdm_slot_track.sv
module tdm_slot_track #(
  parameter int NUM_SLOTS  = 32,
  parameter int SLOT_W     = 5,
  parameter int NUM_GROUPS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc,
  input  logic                  sof,
  input  logic [NUM_GROUPS-1:0] pwr_cfg,
  input  logic                  single_cfg,
  output logic [SLOT_W-1:0]     slot,
  output logic                  par,
  output logic                  grp_on,
  output logic                  single_on
);

  logic [SLOT_W-1:0]     nxt_q;
  logic                  par_q;
  logic [NUM_GROUPS-1:0] pwr_q;
  logic                  single_q;
  logic [NUM_GROUPS-1:0] pwr_now;

  // A frame boundary restarts the slot count, flips the buffer half and
  // takes a fresh copy of the configuration.
  always_comb begin
    slot      = sof ? '0 : nxt_q;
    par       = sof ? ~par_q : par_q;
    pwr_now   = sof ? pwr_cfg : pwr_q;
    single_on = sof ? single_cfg : single_q;
    grp_on    = pwr_now[slot[SLOT_W-1:1]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q    <= '0;
      par_q    <= 1'b0;
      pwr_q    <= '0;
      single_q <= 1'b0;
    end else if (acc) begin
      if (slot == SLOT_W'(NUM_SLOTS - 1)) nxt_q <= '0;
      else                                nxt_q <= slot + SLOT_W'(1);
      par_q    <= par;
      pwr_q    <= pwr_now;
      single_q <= single_on;
    end
  end

endmodule

// File: rtl/tdm_delay_store.sv
module tdm_delay_store #(
  parameter int W      = 8,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              par,
  input  logic [SLOT_W-1:0] slot,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);

  localparam int DEPTH = 2 * (1 << SLOT_W);

  logic [W-1:0]      mem [DEPTH];
  logic [SLOT_W:0]   addr;

  assign addr  = {par, slot};
  // Read before write: the entry still holds the sample from two frames ago.
  assign rdata = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select
  import tdm_bypass_pkg::*;
#(
  parameter int           W    = 8,
  parameter logic [W-1:0] IDLE = 8'hD5
) (
  input  path_e        path,
  input  logic [W-1:0] delayed,
  output logic [W-1:0] sample
);

  // Stand-in for the cancellation stage: same latency, value unchanged.
  function automatic logic [W-1:0] proc_stub(input logic [W-1:0] x);
    return x;
  endfunction

  always_comb begin
    case (path)
      PATH_BYPASS: sample = delayed;
      PATH_PROC:   sample = proc_stub(delayed);
      default:     sample = IDLE;
    endcase
  end

endmodule

// File: rtl/tdm_group_bypass.sv
module tdm_group_bypass
  import tdm_bypass_pkg::*;
#(
  parameter int           NUM_SLOTS = 32,
  parameter int           W         = 8,
  parameter logic [W-1:0] IDLE_CODE = 8'hD5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SLOTS/2-1:0] pwr_up,
  input  logic                   single_ch,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sof,
  input  logic [W-1:0]           rin,
  input  logic [W-1:0]           sin,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_sof,
  output logic [W-1:0]           rout,
  output logic [W-1:0]           sout
);

  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int NUM_GROUPS = NUM_SLOTS / 2;
  localparam int NUM_DIRS   = 2;

  logic              acc;
  logic [SLOT_W-1:0] trk_slot;
  logic              trk_par;
  logic              trk_on;
  logic              trk_single;
  path_e             path;

  logic [W-1:0] d_in  [NUM_DIRS];
  logic [W-1:0] d_old [NUM_DIRS];
  logic [W-1:0] d_out [NUM_DIRS];

  logic         ov_q, osof_q;
  logic [W-1:0] or_q, os_q;

  assign in_ready = !ov_q || out_ready;
  assign acc      = in_valid && in_ready;

  tdm_slot_track #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .NUM_GROUPS(NUM_GROUPS)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .sof       (in_sof),
    .pwr_cfg   (pwr_up),
    .single_cfg(single_ch),
    .slot      (trk_slot),
    .par       (trk_par),
    .grp_on    (trk_on),
    .single_on (trk_single)
  );

  assign path     = pick_path(trk_on, trk_single, trk_slot[0]);
  assign d_in[0]  = rin;
  assign d_in[1]  = sin;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    tdm_delay_store #(.W(W), .SLOT_W(SLOT_W)) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (acc),
      .par  (trk_par),
      .slot (trk_slot),
      .wdata(d_in[d]),
      .rdata(d_old[d])
    );
    tdm_slot_select #(.W(W), .IDLE(IDLE_CODE)) u_sel (
      .path   (path),
      .delayed(d_old[d]),
      .sample (d_out[d])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      osof_q <= 1'b0;
      or_q   <= '0;
      os_q   <= '0;
    end else if (acc) begin
      ov_q   <= 1'b1;
      osof_q <= (trk_slot == '0);
      or_q   <= d_out[0];
      os_q   <= d_out[1];
    end else if (out_ready) begin
      ov_q   <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_sof   = osof_q;
  assign rout      = or_q;
  assign sout      = os_q;

endmodule

// File: rtl/tdm_group_bypass_chk.sv
module tdm_group_bypass_chk #(
  parameter int           W      = 8,
  parameter int           SLOT_W = 5,
  parameter logic [W-1:0] IDLE   = 8'hD5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sof,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sof,
  input logic [W-1:0]      rout,
  input logic [W-1:0]      sout,
  input logic [SLOT_W-1:0] cur_slot,
  input logic              cur_on,
  input logic              cur_single
);

  logic acc;
  assign acc = in_valid && in_ready;

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sof) && $stable(rout) && $stable(sout))); // R2

  AST_BEAT_TO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R3

  AST_SOF_MAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_sof) |=> out_sof); // R4

  AST_IDLE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_on && cur_single && cur_slot[0]) |=> (rout == IDLE && sout == IDLE)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && rout == '0 && sout == '0)); // R10

endmodule

bind tdm_group_bypass tdm_group_bypass_chk #(
  .W     (W),
  .SLOT_W(SLOT_W),
  .IDLE  (IDLE_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sof   (out_sof),
  .rout      (rout),
  .sout      (sout),
  .cur_slot  (trk_slot),
  .cur_on    (trk_on),
  .cur_single(trk_single)
);

// File: tb/sim_tdm_group_bypass.sv
`timescale 1ns/1ps
module sim_tdm_group_bypass;

  localparam logic [7:0] IDLE = 8'hD5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pwr_up = '0;
  logic        single_ch = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [7:0]  rin = '0;
  logic [7:0]  sin = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_sof;
  logic [7:0]  rout, sout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [7:0]  mr [int];
  logic [7:0]  ms [int];
  int          fr = -1;
  int          mslot = 0;
  logic [15:0] m_pwr = '0;
  bit          m_sgl = 1'b0;
  bit          exp_valid = 1'b0;
  bit          exp_sof = 1'b0;
  logic [7:0]  exp_r = '0, exp_s = '0;
  string       exp_tag = "R5";
  bit          acc_last = 1'b0;
  bit          stalled_last = 1'b0;

  always #5 clk = ~clk;

  tdm_group_bypass u0 (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .single_ch(single_ch),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .rin(rin), .sin(sin), .out_valid(out_valid), .out_ready(out_ready),
    .out_sof(out_sof), .rout(rout), .sout(sout)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_valid = 0; exp_sof = 0; exp_r = 0; exp_s = 0;
      fr = -1; mslot = 0; m_pwr = 0; m_sgl = 0;
      mr.delete(); ms.delete();
      acc_last = 0; stalled_last = 0;
    end else begin
      int key, g;
      logic [7:0] old_r, old_s;
      stalled_last = exp_valid && !out_ready;
      acc_last = in_valid && (!exp_valid || out_ready);
      if (acc_last) begin
        if (in_sof) begin
          fr++; mslot = 0; m_pwr = pwr_up; m_sgl = single_ch;  // R9 sampled here only
        end else mslot++;
        key = fr * 32 + mslot;
        g = mslot / 2;
        old_r = mr.exists(key - 64) ? mr[key - 64] : 8'h00;
        old_s = ms.exists(key - 64) ? ms[key - 64] : 8'h00;
        mr[key] = rin; ms[key] = sin;
        if (m_pwr[g] && m_sgl && (mslot % 2 == 1)) begin
          exp_r = IDLE; exp_s = IDLE; exp_tag = "R8";
        end else begin
          exp_r = old_r; exp_s = old_s;
          if (fr < 2)         exp_tag = "R10";
          else if (!m_pwr[g]) exp_tag = "R6";
          else                exp_tag = "R7";
        end
        exp_valid = 1; exp_sof = (mslot == 0);
      end else if (out_ready) begin
        exp_valid = 0;
      end
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!out_valid, "R10", "out_valid in reset", out_valid, 0);
      chk(rout == 0 && sout == 0, "R10", "data in reset", {rout, sout}, 0);
    end else if (!done) begin
      chk(in_ready == (!exp_valid || out_ready), "R1", "in_ready", in_ready, !exp_valid || out_ready);
      chk(out_valid == exp_valid, "R3", "out_valid", out_valid, exp_valid);
      if (exp_valid && out_valid) begin
        chk(out_sof == exp_sof, "R4", "out_sof", out_sof, exp_sof);
        if (stalled_last)
          chk(rout == exp_r && sout == exp_s, "R2", "held beat", {rout, sout}, {exp_r, exp_s});
        else begin
          chk(rout == exp_r, exp_tag, "rout (R5)", rout, exp_r);
          chk(sout == exp_s, exp_tag, "sout (R5)", sout, exp_s);
        end
      end
    end
  end

  always begin
    @(posedge clk); #1;
    out_ready = ($urandom % 4) != 0;
  end

  task automatic send_frame(input int fidx, input logic [15:0] pw, input bit sg,
                            input int chg_at, input logic [15:0] pw2, input bit sg2);
    for (int s = 0; s < 32; s++) begin
      while ($urandom % 5 == 0) begin
        in_valid = 0; @(posedge clk); #1;
      end
      if (s == 0) begin pwr_up = pw; single_ch = sg; end
      if (s == chg_at) begin pwr_up = pw2; single_ch = sg2; end  // R9 mid-frame change
      in_valid = 1; in_sof = (s == 0);
      rin = 8'(fidx * 29 + s * 7 + 3);
      sin = 8'((fidx * 53) ^ (s * 11) ^ 8'h5A);
      do begin @(posedge clk); #1; end while (!acc_last);
    end
    in_valid = 0; in_sof = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    for (int f = 0; f < 4; f++)  send_frame(f, 16'h0000, (f % 2) == 1, -1, 0, 0); // R6
    for (int f = 4; f < 8; f++)  send_frame(f, 16'hFFFF, 0, -1, 0, 0);            // R7
    for (int f = 8; f < 12; f++) send_frame(f, 16'hA5C3, 1, -1, 0, 0);            // R8
    send_frame(12, 16'hFFFF, 1, 10, 16'h0F0F, 0);                                   // R9
    send_frame(13, 16'h0F0F, 0, 17, 16'hFFFF, 1);                                   // R9
    for (int f = 14; f < 17; f++) send_frame(f, 16'hFFFF, 1, -1, 0, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 0;                                                                   // R10
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int f = 20; f < 23; f++) send_frame(f, 16'h3333, 1, -1, 0, 0);           // R10
    repeat (10) @(posedge clk);
    #1 done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule